// File: doc/BRIEF.md
# Converter Alert/Ready Output Controller

This block drives the open-drain alert/ready pin of a data converter. It looks at the sign bits of the upper and lower threshold registers to choose what the pin means. In the normal case the pin shows the alert from the threshold comparator. In this block that alert comes from a simple stand-in that takes two "over upper" and "under lower" flags. One threshold pattern turns the pin into a conversion-ready indicator. In that case the latch and comparator-mode bits have no effect.

In ready mode the meaning of an end-of-conversion strobe depends on the run mode. When the converter runs continuously, each strobe starts a fixed-length active pulse. The length is set in clock cycles, and about 8 µs is typical. When the converter runs in single-shot mode, the strobe sets an active level. That level stays until the next conversion-start request. A polarity bit selects whether the pin is active-low or active-high. A queue field of all ones releases the pin completely. The pin is modelled as a pull-down enable, so the pin is released whenever its logical level is high.

Top module: `alrdy_pin_ctrl`

## Requirements
- R1: Ready mode is selected only when bit 15 (the MSB) of the upper threshold is 1 and bit 15 of the lower threshold is 0. The other three sign-bit combinations select comparator mode.
- R2: When the queue field equals 2'b11, `pin_pulldown` and `pin_active` are both 0 (pin released), whatever the internal state. Any other queue value lets the pin work. Internal ready and latch state is kept while the pin is disabled.
- R3: With polarity 0 the pin is active-low: `pin_pulldown` is 1 exactly when the pin is active. With polarity 1 the pin is active-high: `pin_pulldown` is 1 exactly when the pin is inactive.
- R4: In ready mode with continuous operation, suppose an end-of-conversion strobe is sampled at rising edge k. Then `pin_active` is 1 after edges k+1 through k+PULSE_CYC and 0 after that.
- R5: A strobe that arrives in continuous operation while a pulse is still running restarts the pulse. The pulse then ends PULSE_CYC cycles after the new strobe.
- R6: In ready mode with single-shot operation, a strobe sampled at edge k makes `pin_active` 1 from edge k+1. It stays 1 until a conversion-start request is sampled at some edge j. It is 0 from edge j+1.
- R7: If the end-of-conversion strobe and the conversion-start request are sampled in the same cycle in single-shot operation, the strobe wins and the ready level is set.
- R8: In ready mode the comparator flags, the comparator-mode bit and the latch bit have no effect on the pin.
- R9: In comparator mode the stand-in alert uses the "over upper" flag alone when the comparator-mode bit is 0. It uses the OR of both flags when that bit is 1. A flag sampled at edge k appears at the pin at edge k+1.
- R10: In comparator mode with the latch bit set, an alert stays active after the flags clear. A conversion-start request clears it, with the same timing as R6.
- R11: A synchronous active-high reset clears all state. It leaves `pin_pulldown` and `pin_active` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_hi | input | THR_W | Upper threshold register value |
| thr_lo | input | THR_W | Lower threshold register value |
| pol | input | 1 | Active level: 0 active-low, 1 active-high |
| queue | input | 2 | Queue field; 2'b11 disables the pin |
| cmp_window | input | 1 | Comparator-mode bit for the stand-in alert |
| cmp_latch | input | 1 | Latch bit for the stand-in alert |
| cmp_over | input | 1 | Comparator flag: value above upper threshold |
| cmp_under | input | 1 | Comparator flag: value below lower threshold |
| cont_run | input | 1 | 1 when the converter runs continuously, 0 for single-shot |
| eoc | input | 1 | End-of-conversion strobe, one cycle |
| conv_start | input | 1 | Conversion-start request, one cycle |
| pin_pulldown | output | 1 | Registered open-drain enable: 1 pulls the pin low |
| pin_active | output | 1 | Registered logical active state of the pin |

## Verification
Each input that changes state is captured at one rising edge. The result then shows on both outputs after the next rising edge, so every result is due one full cycle after the capturing edge. Configuration changes follow the same rule: a change to queue or polarity is seen one edge after it is sampled. The bench drives all stimulus on falling edges and samples on the falling edge that follows the edge where the result is due. For the continuous pulse it checks every cycle of the window, and it checks the first cycle after the window to catch an off-by-one length.

// File: rtl/alrdy_pkg.sv
package alrdy_pkg;

  typedef enum logic {
    SRC_CMP = 1'b0,
    SRC_RDY = 1'b1
  } pin_src_e;

  localparam logic [1:0] QUEUE_OFF = 2'b11;

  function automatic pin_src_e pick_src(input logic hi_sign, input logic lo_sign);
    return (hi_sign && !lo_sign) ? SRC_RDY : SRC_CMP;
  endfunction

endpackage

// File: rtl/alrdy_mode_dec.sv
module alrdy_mode_dec
  import alrdy_pkg::*;
#(
  parameter int THR_W = 16
) (
  input  logic [THR_W-1:0] thr_hi,
  input  logic [THR_W-1:0] thr_lo,
  input  logic [1:0]       queue,
  output pin_src_e         src,
  output logic             pin_en
);

  localparam int SIGN_BIT = THR_W - 1;

  always_comb begin
    src    = pick_src(thr_hi[SIGN_BIT], thr_lo[SIGN_BIT]);
    pin_en = (queue != QUEUE_OFF);
  end

endmodule

// File: rtl/alrdy_rdy_timer.sv
module alrdy_rdy_timer #(
  parameter int PULSE_CYC = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic eoc,
  input  logic cont_run,
  input  logic conv_start,
  output logic pulse_on,
  output logic hold_on
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt;
  logic             hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (eoc && cont_run) begin
      cnt <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
    end else if (eoc && !cont_run) begin
      hold_q <= 1'b1;
    end else if (conv_start) begin
      hold_q <= 1'b0;
    end
  end

  assign pulse_on = (cnt != '0);
  assign hold_on  = hold_q;

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD);

  // R5
  pulse_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (eoc && cont_run) |=> (cnt == LOAD));

  // R6
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !eoc) |=> !hold_on);

  // R7
  hold_set_chk: assert property (@(posedge clk) disable iff (rst)
    (eoc && !cont_run) |=> hold_on);

endmodule

// File: rtl/alrdy_cmp_stub.sv
module alrdy_cmp_stub (
  input  logic clk,
  input  logic rst,
  input  logic cmp_window,
  input  logic cmp_latch,
  input  logic cmp_over,
  input  logic cmp_under,
  input  logic conv_start,
  output logic alert
);

  logic raw;
  logic flag_q;

  always_comb begin
    if (cmp_window) raw = cmp_over | cmp_under;
    else            raw = cmp_over;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= raw | (cmp_latch & flag_q & ~conv_start);
  end

  assign alert = flag_q;

  // R10
  latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (alert && cmp_latch && !conv_start) |=> alert);

  // R9
  window_under_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_window && cmp_under) |=> alert);

endmodule

// File: rtl/alrdy_pin_out.sv
module alrdy_pin_out
  import alrdy_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pin_en,
  input  pin_src_e src,
  input  logic     pol,
  input  logic     pulse_on,
  input  logic     hold_on,
  input  logic     cmp_alert,
  output logic     pin_pulldown,
  output logic     pin_active
);

  logic act_c;
  logic low_c;

  always_comb begin
    if (src == SRC_RDY) act_c = pulse_on | hold_on;
    else                act_c = cmp_alert;
    low_c = pol ? ~act_c : act_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_pulldown <= 1'b0;
      pin_active   <= 1'b0;
    end else begin
      pin_pulldown <= pin_en & low_c;
      pin_active   <= pin_en & act_c;
    end
  end

  // R2
  off_release_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_en |=> (!pin_pulldown && !pin_active));

  // R3
  pol_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_en && !pol && src == SRC_RDY && hold_on) |=> pin_pulldown);

  // R8
  rdy_ignores_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_en && src == SRC_RDY && !pulse_on && !hold_on) |=> !pin_active);

endmodule

// File: rtl/alrdy_pin_ctrl.sv
module alrdy_pin_ctrl
  import alrdy_pkg::*;
#(
  parameter int THR_W     = 16,
  parameter int PULSE_CYC = 400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_W-1:0] thr_hi,
  input  logic [THR_W-1:0] thr_lo,
  input  logic             pol,
  input  logic [1:0]       queue,
  input  logic             cmp_window,
  input  logic             cmp_latch,
  input  logic             cmp_over,
  input  logic             cmp_under,
  input  logic             cont_run,
  input  logic             eoc,
  input  logic             conv_start,
  output logic             pin_pulldown,
  output logic             pin_active
);

  pin_src_e src;
  logic     pin_en;
  logic     pulse_on;
  logic     hold_on;
  logic     cmp_alert;

  alrdy_mode_dec #(.THR_W(THR_W)) u_dec (
    .thr_hi (thr_hi),
    .thr_lo (thr_lo),
    .queue  (queue),
    .src    (src),
    .pin_en (pin_en)
  );

  alrdy_rdy_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .eoc        (eoc),
    .cont_run   (cont_run),
    .conv_start (conv_start),
    .pulse_on   (pulse_on),
    .hold_on    (hold_on)
  );

  alrdy_cmp_stub u_cmp (
    .clk        (clk),
    .rst        (rst),
    .cmp_window (cmp_window),
    .cmp_latch  (cmp_latch),
    .cmp_over   (cmp_over),
    .cmp_under  (cmp_under),
    .conv_start (conv_start),
    .alert      (cmp_alert)
  );

  alrdy_pin_out u_out (
    .clk          (clk),
    .rst          (rst),
    .pin_en       (pin_en),
    .src          (src),
    .pol          (pol),
    .pulse_on     (pulse_on),
    .hold_on      (hold_on),
    .cmp_alert    (cmp_alert),
    .pin_pulldown (pin_pulldown),
    .pin_active   (pin_active)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!pin_pulldown && !pin_active));

endmodule

// File: tb/alrdy_pin_ctrl_test.sv
module alrdy_pin_ctrl_test;

  localparam int P = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] thr_hi = 16'h7FFF;
  logic [15:0] thr_lo = 16'h8000;
  logic        pol = 1'b0;
  logic [1:0]  queue = 2'b00;
  logic        cmp_window = 1'b0;
  logic        cmp_latch = 1'b0;
  logic        cmp_over = 1'b0;
  logic        cmp_under = 1'b0;
  logic        cont_run = 1'b0;
  logic        eoc = 1'b0;
  logic        conv_start = 1'b0;
  logic        pin_pulldown;
  logic        pin_active;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alrdy_pin_ctrl #(.THR_W(16), .PULSE_CYC(P)) uut (
    .clk(clk), .rst(rst), .thr_hi(thr_hi), .thr_lo(thr_lo), .pol(pol),
    .queue(queue), .cmp_window(cmp_window), .cmp_latch(cmp_latch),
    .cmp_over(cmp_over), .cmp_under(cmp_under), .cont_run(cont_run),
    .eoc(eoc), .conv_start(conv_start),
    .pin_pulldown(pin_pulldown), .pin_active(pin_active)
  );

  // fields: hi, lo, pol, queue, window, latch, over, under, exp_pulldown, exp_active
  localparam logic [40:0] VEC [12] = '{
    {16'h7FFF, 16'h8000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 idle
    {16'h7FFF, 16'h8000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R9 over
    {16'h7FFF, 16'h8000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 active-high
    {16'h7FFF, 16'h8000, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 inactive low
    {16'h7FFF, 16'h8000, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R9 window under
    {16'h7FFF, 16'h8000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 under ignored
    {16'h7FFF, 16'h8000, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 off
    {16'h7FFF, 16'h8000, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 off pol1
    {16'h8000, 16'h7FFF, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 ready
    {16'hFFFF, 16'h0000, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R8 ready
    {16'hFFFF, 16'h8000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R1 both set
    {16'h0000, 16'h0000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}  // R1 both clear
  };

  task automatic check(input string req, input logic exp_pd, input logic exp_act);
    total++;
    if (pin_pulldown !== exp_pd || pin_active !== exp_act) begin
      bad++;
      $display("FAIL %s: pulldown=%b active=%b expected pulldown=%b active=%b",
               req, pin_pulldown, pin_active, exp_pd, exp_act);
    end
  endtask

  task automatic strobe_eoc();
    eoc = 1'b1;
    @(negedge clk);
    eoc = 1'b0;
  endtask

  task automatic strobe_start();
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset", 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < 12; i++) begin
      thr_hi     = VEC[i][40:25];
      thr_lo     = VEC[i][24:9];
      pol        = VEC[i][8];
      queue      = VEC[i][7:6];
      cmp_window = VEC[i][5];
      cmp_latch  = VEC[i][4];
      cmp_over   = VEC[i][3];
      cmp_under  = VEC[i][2];
      strobe_start();
      @(negedge clk);
      check($sformatf("R1/R2/R3/R8/R9 vector %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R4 continuous pulse length
    thr_hi = 16'h8000; thr_lo = 16'h0000; pol = 1'b0; queue = 2'b00;
    cmp_window = 1'b0; cmp_latch = 1'b0; cmp_over = 1'b0; cmp_under = 1'b0;
    cont_run = 1'b1;
    @(negedge clk);
    strobe_eoc();
    check("R4 before pulse", 1'b0, 1'b0);
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      check("R4 pulse cycle", 1'b1, 1'b1);
    end
    @(negedge clk);
    check("R4 pulse end", 1'b0, 1'b0);

    // R5 restart during pulse
    strobe_eoc();
    check("R5 before pulse", 1'b0, 1'b0);
    repeat (3) begin
      @(negedge clk);
      check("R5 first part", 1'b1, 1'b1);
    end
    strobe_eoc();
    check("R5 at restart", 1'b1, 1'b1);
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      check("R5 restarted pulse", 1'b1, 1'b1);
    end
    @(negedge clk);
    check("R5 restarted end", 1'b0, 1'b0);

    // R3 active-high pulse
    pol = 1'b1;
    @(negedge clk);
    check("R3 pol1 idle", 1'b1, 1'b0);
    strobe_eoc();
    @(negedge clk);
    check("R3 pol1 pulse", 1'b0, 1'b1);
    repeat (P) @(negedge clk);
    check("R3 pol1 after pulse", 1'b1, 1'b0);

    // R6 single-shot hold
    pol = 1'b0; cont_run = 1'b0;
    @(negedge clk);
    strobe_eoc();
    @(negedge clk);
    check("R6 ready set", 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    check("R6 ready held", 1'b1, 1'b1);
    strobe_start();
    check("R6 before clear", 1'b1, 1'b1);
    @(negedge clk);
    check("R6 cleared", 1'b0, 1'b0);

    // R2 disable keeps state
    strobe_eoc();
    @(negedge clk);
    check("R2 ready set", 1'b1, 1'b1);
    queue = 2'b11;
    @(negedge clk);
    check("R2 disabled", 1'b0, 1'b0);
    queue = 2'b00;
    @(negedge clk);
    check("R2 re-enabled keeps ready", 1'b1, 1'b1);
    strobe_start();
    @(negedge clk);
    check("R2 cleared", 1'b0, 1'b0);

    // R7 strobe and start together
    eoc = 1'b1; conv_start = 1'b1;
    @(negedge clk);
    eoc = 1'b0; conv_start = 1'b0;
    @(negedge clk);
    check("R7 strobe wins", 1'b1, 1'b1);
    strobe_start();
    @(negedge clk);
    check("R7 cleared", 1'b0, 1'b0);

    // R10 latch in comparator mode
    thr_hi = 16'h7FFF; thr_lo = 16'h8000; cmp_latch = 1'b1;
    cmp_over = 1'b1;
    @(negedge clk);
    cmp_over = 1'b0;
    @(negedge clk);
    check("R10 alert set", 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    check("R10 alert latched", 1'b1, 1'b1);
    strobe_start();
    @(negedge clk);
    check("R10 alert cleared", 1'b0, 1'b0);

    // R9 without latch the alert follows the flag
    cmp_latch = 1'b0;
    cmp_over = 1'b1;
    @(negedge clk);
    cmp_over = 1'b0;
    @(negedge clk);
    check("R9 alert one cycle", 1'b1, 1'b1);
    @(negedge clk);
    check("R9 alert dropped", 1'b0, 1'b0);

    // R11 reset during a held ready level
    thr_hi = 16'h8000; thr_lo = 16'h0000;
    strobe_eoc();
    @(negedge clk);
    check("R11 ready before reset", 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R11 in reset", 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 ready cleared by reset", 1'b0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule